// File: doc/BRIEF.md
# Byte-Granular Write Wear Tracker

This block keeps a running count of how often each region of a nonvolatile memory array has been written, so that a controller can tell when a region has used up its rated write endurance. Each write request brings the target row, the column, the word currently stored and the word about to be stored. In byte granularity the block compares the two words one byte at a time and charges wear only to the bytes whose value actually changes. In the two coarser granularities every write is charged once, either to the whole row or to the addressed word.

The counters live in a small on-chip table that is indexed directly by the low bits of a composite wear key. A counter that reaches the configured lifetime stays there, and every request that charges an exhausted counter reports an endurance failure together with its completion pulse. The word width follows from the bus geometry: the bus width in bits, times the burst length, times the data rate, divided by eight, gives the number of bytes per word.

Top module: `wear_tracker`

## Requirements
- R1: After reset every counter is zero, `req_ready_o` is high and `done_o` and `fail_o` are low.
- R2: A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` then stays low until the cycle after the `done_o` pulse.
- R3: Granularity code 2'b00 (and 2'b11, which acts the same) selects row mode. The wear key is the row number, and one counter is charged whether or not the data changes. `done_o` rises in the second cycle after acceptance.
- R4: Code 2'b01 selects word mode. The key is row × COLS + column, and one counter is charged whether or not the data changes. The timing is the same as in R3.
- R5: Code 2'b10 selects byte mode. The word holds WB = BUS_W × BURST × RATE / 8 bytes. These are examined one per cycle from byte WB−1 down to byte 0, where byte i is data bits [8i+7:8i]. `done_o` rises WB+1 cycles after acceptance.
- R6: In byte mode only bytes whose old and new values differ charge a counter. A request with identical words charges nothing and reports no failure.
- R7: The byte-mode key is row × (COLS × WB) + column × WB + byte index.
- R8: The table index is the key modulo DEPTH, with DEPTH a power of two. A counter not charged since reset starts at zero, and each charge adds one, so the first write counts as 1.
- R9: `fail_o` is high with `done_o` when any counter charged by that request has reached LIFE after the charge. Counters saturate at LIFE, so later charges to them fail again.
- R10: `done_o` is a one-cycle pulse per request, and `fail_o` is never high while `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_mode_i | input | 2 | Granularity: 00 row, 01 word, 10 byte, 11 row |
| req_row_i | input | $clog2(ROWS) | Row being written |
| req_col_i | input | $clog2(COLS) | Column (word within row) being written |
| req_old_i | input | WB×8 | Word currently stored |
| req_new_i | input | WB×8 | Word to be stored |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Endurance failure, valid with done_o |

## Verification
Row-mode and word-mode requests complete two cycles after the edge that accepts them. A byte-mode request takes WB+1 cycles, because every byte costs a cycle whether or not it changed. The bench drives on the falling edge and samples one falling edge after each rising edge. For every request it checks that `done_o` stays low in each cycle before the one it is due, is high exactly in that cycle together with the expected `fail_o`, and that `req_ready_o` returns one cycle later. Expected failures come from counting charges per table index by hand, and this includes keys that alias onto the same index from different modes.

// File: rtl/wt_pkg.sv
package wt_pkg;
   typedef enum logic [1:0] {
      WT_ROW     = 2'b00,
      WT_WORD    = 2'b01,
      WT_BYTE    = 2'b10,
      WT_ROW_ALT = 2'b11
   } wt_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_SCAN = 2'b01,
      ST_DONE = 2'b10
   } wt_state_e;
endpackage

// File: rtl/wt_byte_diff.sv
module wt_byte_diff #(
   parameter int WB = 4
) (
   input  logic [WB*8-1:0] old_i,
   input  logic [WB*8-1:0] new_i,
   output logic [WB-1:0]   chg_o
);
   for (genvar b = 0; b < WB; b++) begin : g_lane
      assign chg_o[b] = (old_i[b*8 +: 8] != new_i[b*8 +: 8]);
   end
endmodule

// File: rtl/wt_key_gen.sv
module wt_key_gen
   import wt_pkg::*;
#(
   parameter int COLS  = 8,
   parameter int WB    = 4,
   parameter int ROW_W = 4,
   parameter int COL_W = 3,
   parameter int BI_W  = 2,
   parameter int IDX_W = 6
) (
   input  wt_mode_e           mode_i,
   input  logic [ROW_W-1:0]   row_i,
   input  logic [COL_W-1:0]   col_i,
   input  logic [BI_W-1:0]    bidx_i,
   output logic [IDX_W-1:0]   idx_o
);
   // Arithmetic is carried out at IDX_W bits, which is the key modulo 2**IDX_W.
   localparam int ROW_BYTES = COLS * WB;

   logic [IDX_W-1:0] row_x, col_x, bidx_x;
   assign row_x  = IDX_W'(row_i);
   assign col_x  = IDX_W'(col_i);
   assign bidx_x = IDX_W'(bidx_i);

   always_comb begin
      unique case (mode_i)
         WT_WORD: idx_o = row_x * IDX_W'(COLS) + col_x;
         WT_BYTE: idx_o = row_x * IDX_W'(ROW_BYTES) + col_x * IDX_W'(WB) + bidx_x;
         default: idx_o = row_x;
      endcase
   end
endmodule

// File: rtl/wt_cnt_table.sv
module wt_cnt_table #(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6,
   parameter int CNT_W = 4,
   parameter int LIFE  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] LIFE_C = CNT_W'(LIFE);

   logic [CNT_W-1:0] cnt_q [DEPTH];
   logic [CNT_W-1:0] cur, nxt;

   assign cur   = cnt_q[idx_i];
   assign nxt   = (cur >= LIFE_C) ? LIFE_C : cur + CNT_W'(1);
   assign hit_o = upd_i && (nxt == LIFE_C);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
      end else if (upd_i) begin
         cnt_q[idx_i] <= nxt;
      end
   end
endmodule

// File: rtl/wear_tracker.sv
module wear_tracker
   import wt_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int BURST = 2,
   parameter int RATE  = 2,
   parameter int COLS  = 8,
   parameter int ROWS  = 16,
   parameter int DEPTH = 64,
   parameter int LIFE  = 3,
   parameter int CNT_W = 4,
   localparam int WB    = BUS_W * BURST * RATE / 8,
   localparam int DW    = WB * 8,
   localparam int ROW_W = $clog2(ROWS),
   localparam int COL_W = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid_i,
   output logic             req_ready_o,
   input  logic [1:0]       req_mode_i,
   input  logic [ROW_W-1:0] req_row_i,
   input  logic [COL_W-1:0] req_col_i,
   input  logic [DW-1:0]    req_old_i,
   input  logic [DW-1:0]    req_new_i,
   output logic             done_o,
   output logic             fail_o
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam int BI_W  = (WB > 1) ? $clog2(WB) : 1;
   localparam logic [BI_W-1:0] LAST_B = BI_W'(WB - 1);

   if ((BUS_W * BURST * RATE) % 8 != 0) begin : g_bad_word
      $error("word geometry must give whole bytes");
   end
   if (DEPTH < 2 || DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (ROWS < 2 || COLS < 2) begin : g_bad_geom
      $error("ROWS and COLS must each be at least 2");
   end
   if (LIFE < 1 || LIFE >= (1 << CNT_W)) begin : g_bad_life
      $error("LIFE must fit in CNT_W bits");
   end

   wt_state_e        state_q;
   wt_mode_e         mode_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic [WB-1:0]    chg_q, chg_in;
   logic [BI_W-1:0]  bidx_q;
   logic             fail_q;
   logic             upd, hit;
   logic [IDX_W-1:0] idx;

   wt_byte_diff #(.WB(WB)) u_diff (
      .old_i (req_old_i),
      .new_i (req_new_i),
      .chg_o (chg_in)
   );

   wt_key_gen #(
      .COLS(COLS), .WB(WB), .ROW_W(ROW_W), .COL_W(COL_W),
      .BI_W(BI_W), .IDX_W(IDX_W)
   ) u_key (
      .mode_i (mode_q),
      .row_i  (row_q),
      .col_i  (col_q),
      .bidx_i (bidx_q),
      .idx_o  (idx)
   );

   wt_cnt_table #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .LIFE(LIFE)
   ) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .upd_i (upd),
      .idx_i (idx),
      .hit_o (hit)
   );

   // Row and word modes charge unconditionally; byte mode only on a changed lane.
   assign upd = (state_q == ST_SCAN) &&
                ((mode_q != WT_BYTE) || chg_q[bidx_q]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= WT_ROW;
         row_q   <= '0;
         col_q   <= '0;
         chg_q   <= '0;
         bidx_q  <= '0;
         fail_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid_i) begin
               mode_q  <= wt_mode_e'(req_mode_i);
               row_q   <= req_row_i;
               col_q   <= req_col_i;
               chg_q   <= chg_in;
               fail_q  <= 1'b0;
               bidx_q  <= (wt_mode_e'(req_mode_i) == WT_BYTE) ? LAST_B : '0;
               state_q <= ST_SCAN;
            end
            ST_SCAN: begin
               fail_q <= fail_q | hit;
               if (bidx_q == '0) state_q <= ST_DONE;
               else              bidx_q  <= bidx_q - BI_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign done_o      = (state_q == ST_DONE);
   assign fail_o      = (state_q == ST_DONE) && fail_q;
endmodule

// File: rtl/wt_checker.sv
module wt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid_i,
   input logic       req_ready_o,
   input logic [1:0] req_mode_i,
   input logic       done_o,
   input logic       fail_o
);
   // R10
   a_r10_fail_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> done_o);
   // R10
   a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R2
   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o) |=> (!req_ready_o && !done_o));
   // R2
   a_r2_not_ready_in_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !req_ready_o);
   // R2
   a_r2_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> req_ready_o);
   // R3
   a_r3_row_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && (req_mode_i == 2'b00 || req_mode_i == 2'b11))
      |=> ##1 done_o);
   // R4
   a_r4_word_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_ready_o && req_mode_i == 2'b01) |=> ##1 done_o);
endmodule

bind wear_tracker wt_checker u_chk (.*);

// File: tb/wear_tracker_tb.sv
module wear_tracker_tb;
   localparam int WB = 8 * 2 * 2 / 8;
   localparam int DW = WB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid_i = 1'b0;
   logic          req_ready_o;
   logic [1:0]    req_mode_i = 2'b00;
   logic [3:0]    req_row_i = '0;
   logic [2:0]    req_col_i = '0;
   logic [DW-1:0] req_old_i = '0;
   logic [DW-1:0] req_new_i = '0;
   logic          done_o, fail_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   wear_tracker u_dut (.*);

   // {mode, row, col, old, new, expected fail}; LIFE=3, DEPTH=64, COLS=8, WB=4
   localparam int NV = 14;
   localparam logic [73:0] VEC [NV] = '{
      {2'b10, 4'd1, 3'd2, 32'h0000_0000, 32'h0000_00FF, 1'b0}, // R7 key 40 ->1
      {2'b10, 4'd1, 3'd2, 32'h0000_0000, 32'h0000_FF00, 1'b0}, // R7 key 41 ->1
      {2'b10, 4'd1, 3'd2, 32'h0000_0000, 32'h0000_00FF, 1'b0}, // R8 key 40 ->2
      {2'b10, 4'd1, 3'd2, 32'h0000_0000, 32'h0000_0001, 1'b1}, // R9 key 40 ->3
      {2'b10, 4'd1, 3'd2, 32'h1234_5678, 32'h1234_5678, 1'b0}, // R6 nothing
      {2'b00, 4'd0, 3'd0, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 idx 0 ->1
      {2'b00, 4'd3, 3'd5, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 idx 3 ->1
      {2'b01, 4'd5, 3'd1, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R4 idx 41 ->2
      {2'b01, 4'd5, 3'd1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1}, // R4 idx 41 ->3
      {2'b10, 4'd3, 3'd0, 32'h0000_0000, 32'hAA00_0000, 1'b0}, // R8 99->35 ->1
      {2'b10, 4'd0, 3'd0, 32'h0000_0000, 32'h8000_0001, 1'b0}, // R5 idx 3,0 ->2
      {2'b11, 4'd0, 3'd7, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R3 idx 0 ->3
      {2'b01, 4'd0, 3'd3, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R4 idx 3 ->3
      {2'b10, 4'd1, 3'd2, 32'h0000_0000, 32'h0000_0002, 1'b1}  // R9 saturated
   };

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic run_req(input logic [1:0] mode, input logic [3:0] row,
                          input logic [2:0] col, input logic [DW-1:0] old_w,
                          input logic [DW-1:0] new_w, input bit exp_fail,
                          input string tag);
      int lat;
      lat = (mode == 2'b10) ? WB : 1;
      @(negedge clk);
      check(req_ready_o == 1'b1, "R2", "ready before request", int'(req_ready_o), 1);
      req_valid_i = 1'b1;
      req_mode_i  = mode;
      req_row_i   = row;
      req_col_i   = col;
      req_old_i   = old_w;
      req_new_i   = new_w;
      @(posedge clk);
      @(negedge clk);
      req_valid_i = 1'b0;
      check(req_ready_o == 1'b0, "R2", "ready after accept", int'(req_ready_o), 0);
      check(done_o == 1'b0, "R10", "done right after accept", int'(done_o), 0);
      for (int k = 1; k <= lat; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k < lat) begin
            check(done_o == 1'b0, "R5", "done early", int'(done_o), 0);
            check(fail_o == 1'b0, "R10", "fail without done", int'(fail_o), 0);
         end else begin
            check(done_o == 1'b1, tag, "done due", int'(done_o), 1);
            check(fail_o == exp_fail, tag, "fail with done", int'(fail_o), int'(exp_fail));
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(done_o == 1'b0, "R10", "done single pulse", int'(done_o), 0);
      check(req_ready_o == 1'b1, "R2", "ready after done", int'(req_ready_o), 1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);
      check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
      check(fail_o == 1'b0, "R1", "fail after reset", int'(fail_o), 0);

      for (int i = 0; i < NV; i++) begin
         run_req(VEC[i][73:72], VEC[i][71:68], VEC[i][67:65],
                 VEC[i][64:33], VEC[i][32:1], VEC[i][0], "R9");
      end

      // R1: reset clears counters; idx 0 was at LIFE, now counts from 1
      do_reset();
      check(req_ready_o == 1'b1, "R1", "ready after second reset", int'(req_ready_o), 1);
      run_req(2'b00, 4'd0, 3'd0, '0, '0, 1'b0, "R1");
      run_req(2'b00, 4'd0, 3'd0, '0, '0, 1'b0, "R8");
      run_req(2'b00, 4'd0, 3'd0, '0, '0, 1'b1, "R8");
      // R6: unchanged word in byte mode does not charge row 0 byte keys
      run_req(2'b10, 4'd0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6");
      // R7: all four lanes change, keys 4..7 at row 0 col 1, each reaches 1
      run_req(2'b10, 4'd0, 3'd1, 32'h0000_0000, 32'h0101_0101, 1'b0, "R7");
      run_req(2'b10, 4'd0, 3'd1, 32'h0000_0000, 32'h0101_0101, 1'b0, "R7");
      run_req(2'b10, 4'd0, 3'd1, 32'h0000_0000, 32'h0100_0000, 1'b1, "R9");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule